// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the raw D+ and D- lines of a low-speed USB link, sampled by a system clock running at ten times the bit rate, and turns each packet into a stream of bytes written into a buffer of fixed capacity. Both lines first pass through a two-flop synchronizer. A controller then watches for J-to-K transitions during the sync pattern. On each transition it restarts a phase counter, so its sampling point sits in the middle of the bit. When two K bits in a row mark the end of sync, it switches to a free-running sampler with one sample every `BIT_CLKS` clocks.

Each sample is NRZI-decoded against the previous line level. A run counter finds and drops stuffed bits. Data bits are collected least significant bit first, and each finished byte is written to the next buffer address. An SE0 ends the packet. The receiver then pulses a done strobe and shows how many whole bytes it stored; sync is not counted and a partial byte is dropped. A byte that arrives when the buffer is already full raises an overflow pulse, and the rest of that packet is ignored. If the sync pattern breaks off and no further K edge arrives, the receiver reports a framing error and goes back to idle.

Controller states and transitions:
- `ST_IDLE` goes to `ST_LOCK` on a J-to-K edge.
- `ST_LOCK` samples one bit after that edge. If it sees K, it goes to `ST_RECV`; otherwise it goes to `ST_HUNT`.
- `ST_HUNT` goes back to `ST_LOCK` on the next J-to-K edge. If `HUNT_LIMIT` clocks pass with no edge, it goes to `ST_IDLE` and signals a framing error.
- `ST_RECV` goes to `ST_IDLE` when an SE0 ends the packet. It goes to `ST_SKIP` on overflow.
- `ST_SKIP` goes to `ST_IDLE` when it sees an SE0.

Top module: `usb_ls_rx`

## Requirements
- R1: During reset and after it, `wr_en`, `pkt_done`, `pkt_overflow` and `frame_err` are 0 and `pkt_len` is 0. The idle line is J, meaning D+=0 and D-=1. K means D+=1 and D-=0.
- R2: After a J-to-K edge, the line is sampled again one bit later. Reception starts only if that sample is K. If it is J, the receiver goes back to hunting for edges and writes nothing.
- R3: Each received bit is decoded from the D- level. A bit is 1 when the sample matches the previous sample and 0 when it differs.
- R4: Data bits fill each byte from bit 0 (first received) to bit 7. The n-th whole byte of a packet, counting from 0, is written with one `wr_en` pulse at `wr_addr` = n.
- R5: After six consecutive decoded 1s, the next sample is a stuffed bit and is discarded. The last K of the sync pattern counts as the first 1 of such a run.
- R6: An SE0 ends the packet if it is sampled on a stuffed bit or on any data bit other than bit 0 of a byte. The end of packet gives a one-clock `pkt_done` with `pkt_len` equal to the number of whole bytes stored. Bits of an unfinished byte are dropped.
- R7: An SE0 sampled on bit 0 of a byte does not end the packet and is decoded as a K level.
- R8: If a byte completes when `DEPTH` bytes are already stored, it is not written. `pkt_overflow` pulses for one clock and there is no `pkt_done`. The rest of the packet is ignored until an SE0, and the next packet is received normally.
- R9: If a J sample rejects the lock and no J-to-K edge follows within `HUNT_LIMIT` clocks, `frame_err` pulses for one clock and the receiver returns to idle.
- R10: `pkt_len` holds its value until the next `pkt_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `BIT_CLKS` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_dp | input | 1 | Raw D+ line sample |
| usb_dm | input | 1 | Raw D- line sample |
| wr_en | output | 1 | Buffer write strobe, one clock per byte |
| wr_addr | output | $clog2(DEPTH) | Buffer write address |
| wr_data | output | 8 | Byte being written |
| pkt_done | output | 1 | One-clock end-of-packet strobe |
| pkt_len | output | $clog2(DEPTH+1) | Whole bytes stored in the last completed packet |
| pkt_overflow | output | 1 | One-clock pulse when a byte finds the buffer full |
| frame_err | output | 1 | One-clock pulse when sync breaks off |

## Verification
The hardest case to reach from the ports is an SE0 that lands exactly on bit 0 of a byte, with no stuffed bit pending at that moment. Only then does the single-bit exemption apply instead of the end-of-packet rule. The bench line encoder reaches it by tracking the current line level at each byte boundary. It forces bit 0 of the chosen byte to whatever value leaves the line at K, drives SE0 for that one bit, and updates the expected byte to match. The overflow case is reached with a packet one byte longer than the buffer. Stuffing is exercised with runs of 0xFF bytes that cross byte boundaries.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

    // D- level that represents K on the bus
    localparam logic LVL_K = 1'b0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK,
        ST_HUNT,
        ST_RECV,
        ST_SKIP
    } rx_state_t;

endpackage

// File: rtl/usb_ls_rx_sync.sv
module usb_ls_rx_sync #(
    parameter int           WIDTH   = 2,
    parameter int           STAGES  = 2,
    parameter logic [1:0]   RST_VAL = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= WIDTH'(RST_VAL);
                end else begin
                    if (s == 0) stage_q[s] <= d_in;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/usb_ls_rx_nrzi.sv
module usb_ls_rx_nrzi #(
    parameter int RUN = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,        // load starting level at end of sync
    input  logic arm_level,
    input  logic smp,        // one pulse per bit centre
    input  logic level,      // D- level at the sample
    output logic data_vld,
    output logic data_bit,
    output logic stuff_vld
);

    localparam int RW = $clog2(RUN + 1);

    logic          prev_q;
    logic [RW-1:0] ones_q;
    logic          at_stuff;

    assign at_stuff  = (ones_q == RW'(RUN));
    assign data_bit  = (level == prev_q);
    assign data_vld  = smp && !at_stuff;
    assign stuff_vld = smp && at_stuff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            ones_q <= '0;
        end else if (arm) begin
            prev_q <= arm_level;
            ones_q <= RW'(1);          // trailing sync K counts as a 1
        end else if (smp) begin
            prev_q <= level;
            if (at_stuff)            ones_q <= '0;
            else if (level == prev_q) ones_q <= ones_q + 1'b1;
            else                     ones_q <= '0;
        end
    end

    // R5: the run counter never passes the stuffing threshold
    p_run_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= RW'(RUN));

    // R5: the sample after a stuffed bit restarts the run at zero
    p_stuff_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stuff_vld && !arm) |=> (ones_q == '0));

endmodule

// File: rtl/usb_ls_rx_ctrl.sv
module usb_ls_rx_ctrl
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CLKS   = 10,
    parameter int DEPTH      = 8,
    parameter int HUNT_LIMIT = 32,
    parameter int AW         = 3,
    parameter int LW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_dp,
    input  logic          line_dm,
    input  logic          data_vld,
    input  logic          data_bit,
    input  logic          stuff_vld,
    output logic          smp,
    output logic          arm,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          pkt_done,
    output logic [LW-1:0] pkt_len,
    output logic          pkt_overflow,
    output logic          frame_err
);

    localparam int LOCK_AT = BIT_CLKS + BIT_CLKS/2 - 2;
    localparam int CNT_MAX = (LOCK_AT > HUNT_LIMIT) ? LOCK_AT : HUNT_LIMIT;
    localparam int CW      = $clog2(CNT_MAX + 1);

    rx_state_t     st_q, st_nx;
    logic [CW-1:0] cnt_q;
    logic          dm_q;
    logic [2:0]    bit_idx_q;
    logic [7:0]    sr_q;
    logic [LW-1:0] wcnt_q;

    logic line_k, line_se0, edge_k, lock_smp;
    logic ev_end, byte_fin, ev_wr, ev_ovf, ev_tmo, room;

    assign line_k   = line_dp && !line_dm;
    assign line_se0 = !line_dp && !line_dm;
    assign edge_k   = dm_q && line_k;
    assign smp      = (st_q == ST_RECV) && (cnt_q == CW'(BIT_CLKS - 1));
    assign lock_smp = (st_q == ST_LOCK) && (cnt_q == CW'(LOCK_AT));
    assign arm      = lock_smp && line_k;
    assign room     = (wcnt_q < LW'(DEPTH));

    assign ev_end   = smp && line_se0 && (stuff_vld || (bit_idx_q != 3'd0));
    assign byte_fin = data_vld && (bit_idx_q == 3'd7) && !ev_end;
    assign ev_wr    = byte_fin && room;
    assign ev_ovf   = byte_fin && !room;
    assign ev_tmo   = (st_q == ST_HUNT) && !edge_k && (cnt_q == CW'(HUNT_LIMIT - 1));

    // next-state decision
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: if (edge_k) st_nx = ST_LOCK;
            ST_LOCK: if (lock_smp) st_nx = line_k ? ST_RECV : ST_HUNT;
            ST_HUNT: begin
                if (edge_k)      st_nx = ST_LOCK;
                else if (ev_tmo) st_nx = ST_IDLE;
            end
            ST_RECV: begin
                if (ev_end)      st_nx = ST_IDLE;
                else if (ev_ovf) st_nx = ST_SKIP;
            end
            ST_SKIP: if (line_se0) st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // timing and byte assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            dm_q      <= 1'b1;
            bit_idx_q <= '0;
            sr_q      <= '0;
            wcnt_q    <= '0;
        end else begin
            dm_q <= line_dm;
            if ((st_nx != st_q) || smp)     cnt_q <= '0;
            else if (cnt_q != CW'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;

            if (arm) begin
                bit_idx_q <= '0;
                wcnt_q    <= '0;
            end else begin
                if (data_vld && !ev_end) begin
                    bit_idx_q <= bit_idx_q + 1'b1;
                    sr_q      <= {data_bit, sr_q[7:1]};
                end
                if (ev_wr) wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en        <= 1'b0;
            wr_addr      <= '0;
            wr_data      <= '0;
            pkt_done     <= 1'b0;
            pkt_len      <= '0;
            pkt_overflow <= 1'b0;
            frame_err    <= 1'b0;
        end else begin
            wr_en        <= ev_wr;
            pkt_done     <= ev_end;
            pkt_overflow <= ev_ovf;
            frame_err    <= ev_tmo;
            if (ev_wr) begin
                wr_addr <= wcnt_q[AW-1:0];
                wr_data <= {data_bit, sr_q[7:1]};
            end
            if (ev_end) pkt_len <= wcnt_q;
        end
    end

    // R6: end-of-packet strobe lasts one clock
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    // R6: reported length never exceeds buffer capacity
    p_len_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (pkt_len <= LW'(DEPTH)));

    // R8: overflow only with a full buffer, then skipping
    p_ovf_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_overflow |-> ((wcnt_q == LW'(DEPTH)) && (st_q != ST_RECV)));

    // R4: one event kind per clock on the result outputs
    p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, pkt_done, pkt_overflow, frame_err}));

    // R9: framing error comes from hunting and lands in idle
    p_tmo_from_hunt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> ((st_q == ST_IDLE) && ($past(st_q) == ST_HUNT)));

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
    import usb_ls_rx_pkg::*;
#(
    parameter int BIT_CLKS   = 10,
    parameter int DEPTH      = 8,
    parameter int HUNT_LIMIT = 32,
    parameter int STUFF_RUN  = 6,
    parameter int SYNC_FF    = 2,
    localparam int AW        = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          usb_dp,
    input  logic          usb_dm,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          pkt_done,
    output logic [LW-1:0] pkt_len,
    output logic          pkt_overflow,
    output logic          frame_err
);

    logic [1:0] line_s;
    logic       smp, arm, data_vld, data_bit, stuff_vld;

    usb_ls_rx_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_FF),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({usb_dp, usb_dm}),
        .d_out (line_s)
    );

    usb_ls_rx_nrzi #(
        .RUN (STUFF_RUN)
    ) u_nrzi (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .arm_level (LVL_K),
        .smp       (smp),
        .level     (line_s[0]),
        .data_vld  (data_vld),
        .data_bit  (data_bit),
        .stuff_vld (stuff_vld)
    );

    usb_ls_rx_ctrl #(
        .BIT_CLKS   (BIT_CLKS),
        .DEPTH      (DEPTH),
        .HUNT_LIMIT (HUNT_LIMIT),
        .AW         (AW),
        .LW         (LW)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_dp      (line_s[1]),
        .line_dm      (line_s[0]),
        .data_vld     (data_vld),
        .data_bit     (data_bit),
        .stuff_vld    (stuff_vld),
        .smp          (smp),
        .arm          (arm),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .pkt_done     (pkt_done),
        .pkt_len      (pkt_len),
        .pkt_overflow (pkt_overflow),
        .frame_err    (frame_err)
    );

endmodule

// File: tb/usb_ls_rx_test.sv
module usb_ls_rx_test;

    localparam int CLK_PERIOD = 10;
    localparam int BITC       = 10;
    localparam int DEPTH      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dp = 1'b0;
    logic       dm = 1'b1;
    logic       wr_en, pkt_done, pkt_overflow, frame_err;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [3:0] pkt_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_ls_rx uut (
        .clk (clk), .rst_n (rst_n), .usb_dp (dp), .usb_dm (dm),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .pkt_done (pkt_done), .pkt_len (pkt_len),
        .pkt_overflow (pkt_overflow), .frame_err (frame_err)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int exp_wr[$];
    int exp_len[$];
    int ovf_seen = 0, err_seen = 0, done_seen = 0;
    logic [7:0] pkt [16];
    bit cur;          // 1 = J, 0 = K
    int ones;

    task automatic tally(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        int e;
        if (rst_n && !finished) begin
            if (wr_en) begin
                if (exp_wr.size() == 0) tally(0, "R4", "unexpected write", int'({wr_addr, wr_data}), -1);
                else begin
                    e = exp_wr.pop_front();
                    tally(int'({wr_addr, wr_data}) == e, "R3", "write addr/data", int'({wr_addr, wr_data}), e);
                end
            end
            if (pkt_done) begin
                done_seen++;
                if (exp_len.size() == 0) tally(0, "R6", "unexpected done", int'(pkt_len), -1);
                else begin
                    e = exp_len.pop_front();
                    tally(int'(pkt_len) == e, "R6", "packet length", int'(pkt_len), e);
                end
            end
            if (pkt_overflow) ovf_seen++;
            if (frame_err) err_seen++;
        end
    end

    task automatic put(bit p, bit m);
        dp = p;
        dm = m;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic lvl(bit j);
        put(!j, j);
    endtask

    // n bytes from pkt[], extra trailing zero bits, dribble SE0 on bit 0 of byte drib
    task automatic send_pkt(int n, int extra, int drib);
        logic [7:0] d;
        bit bv;
        for (int k = 0; k < 8; k++) lvl((k == 7) ? 1'b0 : 1'(k % 2));
        cur  = 1'b0;
        ones = 1;
        if (n <= DEPTH) exp_len.push_back(n);
        for (int i = 0; i < n; i++) begin
            d = pkt[i];
            if (i == drib) d[0] = (cur == 1'b0);
            if (i < DEPTH) exp_wr.push_back((i << 8) | int'(d));
            for (int b = 0; b < 8; b++) begin
                bv = d[b];
                if (bv) ones++;
                else begin cur = ~cur; ones = 0; end
                if (i == drib && b == 0) put(1'b0, 1'b0);
                else lvl(cur);
                if (ones == 6) begin cur = ~cur; lvl(cur); ones = 0; end
            end
        end
        for (int j = 0; j < extra; j++) begin cur = ~cur; lvl(cur); end
        put(1'b0, 1'b0);
        put(1'b0, 1'b0);
        for (int j = 0; j < 8; j++) lvl(1'b1);
    endtask

    task automatic end_scn(string req, int o0, int e0, int d0, int eo, int ee, int ed);
        tally(exp_wr.size() == 0, req, "pending writes", exp_wr.size(), 0);
        tally(exp_len.size() == 0, req, "pending done", exp_len.size(), 0);
        tally(ovf_seen - o0 == eo, req, "overflow pulses", ovf_seen - o0, eo);
        tally(err_seen - e0 == ee, req, "frame errors", err_seen - e0, ee);
        tally(done_seen - d0 == ed, req, "done pulses", done_seen - d0, ed);
        exp_wr.delete();
        exp_len.delete();
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int o0, e0, d0;
        repeat (3) @(negedge clk);
        // R1: reset state
        tally(!wr_en && !pkt_done && !pkt_overflow && !frame_err, "R1", "outputs in reset",
              int'({wr_en, pkt_done, pkt_overflow, frame_err}), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        tally(int'({wr_en, pkt_done, pkt_overflow, frame_err}) == 0, "R1", "outputs after reset",
              int'({wr_en, pkt_done, pkt_overflow, frame_err}), 0);
        tally(pkt_len == 0, "R1", "length after reset", int'(pkt_len), 0);

        // R3 R4: mixed data
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        pkt[0] = 8'hC3; pkt[1] = 8'h5A; pkt[2] = 8'h00;
        send_pkt(3, 0, -1);
        end_scn("R4", o0, e0, d0, 0, 0, 1);

        // R5: long runs of ones force stuffing across byte edges
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'h3F;
        send_pkt(4, 0, -1);
        end_scn("R5", o0, e0, d0, 0, 0, 1);

        // R6: partial byte dropped at SE0
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        pkt[0] = 8'h96; pkt[1] = 8'h01;
        send_pkt(2, 5, -1);
        end_scn("R6", o0, e0, d0, 0, 0, 1);
        tally(pkt_len == 2, "R10", "length held after packet", int'(pkt_len), 2);

        // R7: single SE0 on bit 0 of byte 1
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        pkt[0] = 8'h2D; pkt[1] = 8'hB4; pkt[2] = 8'h81;
        send_pkt(3, 0, 1);
        end_scn("R7", o0, e0, d0, 0, 0, 1);

        // R8: one byte more than the buffer holds
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        for (int i = 0; i < DEPTH + 1; i++) pkt[i] = 8'(8'h10 + i * 8'h21);
        send_pkt(DEPTH + 1, 0, -1);
        end_scn("R8", o0, e0, d0, 1, 0, 0);
        tally(pkt_len == 3, "R10", "length held over overflow", int'(pkt_len), 3);
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        pkt[0] = 8'h11;
        send_pkt(1, 0, -1);
        end_scn("R8", o0, e0, d0, 0, 0, 1);

        // R2 R9: sync broken off after two K-J pairs
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        lvl(1'b0); lvl(1'b1); lvl(1'b0); lvl(1'b1);
        for (int j = 0; j < 10; j++) lvl(1'b1);
        end_scn("R2", o0, e0, d0, 0, 1, 0);
        tally(pkt_len == 1, "R10", "length held over frame error", int'(pkt_len), 1);

        // R9: lone K then idle, then a normal packet
        o0 = ovf_seen; e0 = err_seen; d0 = done_seen;
        lvl(1'b0);
        for (int j = 0; j < 10; j++) lvl(1'b1);
        pkt[0] = 8'hA5; pkt[1] = 8'hE7;
        send_pkt(2, 0, -1);
        end_scn("R9", o0, e0, d0, 0, 1, 1);

        finished = 1;
        summary();
        $finish;
    end

endmodule